// File: doc/BRIEF.md
# Interval Timer Count and Status Snapshot Path

This block is the snapshot and readout path of a three-channel interval timer. Software writes a command byte to the timer's control port (bus address 3). A single command can freeze the running count and capture a status byte for any chosen set of channels. The processor then reads each channel's data port (bus addresses 0 to 2) and receives those snapshots in a fixed order. When nothing is frozen, a read returns the live count. The down-counters, output waveform logic and gate handling live elsewhere. Their values arrive here as inputs: live counts, counting mode, access width, BCD flag, output level and null-count flag.

Each channel runs a four-state machine:

- `CH_IDLE`: nothing frozen.
- `CH_CNT`: count frozen.
- `CH_STS`: status frozen.
- `CH_BOTH`: count and status both frozen.

Within one cycle, a read is applied first and a latch request second. The transitions are:

- A status latch takes `CH_IDLE` to `CH_STS` and `CH_CNT` to `CH_BOTH`.
- A count latch takes `CH_IDLE` to `CH_CNT` and `CH_STS` to `CH_BOTH`.
- A read in `CH_BOTH` returns the status and moves to `CH_CNT`.
- A read in `CH_STS` returns the status and moves to `CH_IDLE`.
- A read that delivers the final frozen count byte moves `CH_CNT` to `CH_IDLE`.
- A mode word written for the channel forces `CH_IDLE` from any state.

Top module: `pit_readback`

## Requirements
- R1: After reset every channel is in `CH_IDLE` with its byte pointer on the low byte. The first data-port read of a two-byte channel returns the live low byte, and the second returns the live high byte.
- R2: A control-port write whose bits 7:6 are 11 and whose bit 0 is 0 is a snapshot command. Bit 5 = 0 requests a count latch and bit 4 = 0 requests a status latch. Bits 1, 2 and 3 select channels 0, 1 and 2. A command with bit 0 = 1 is ignored, so later reads return live values.
- R3: One command freezes the counts of all selected channels in the same cycle. Each channel is released only by its own reads, and the other channels stay frozen.
- R4: A frozen count ignores later changes to the live count. Access code 01 returns the low byte in one read, and code 10 returns the high byte in one read. Code 11 returns the low byte and then the high byte over two reads. Reads after that return the live count.
- R5: A count latch request aimed at a channel whose frozen count is still unread is ignored.
- R6: The status byte is {output level, null-count, access code[1:0], counting mode[2:0], BCD}, from bit 7 down to bit 0, sampled in the command's cycle. A status request to a channel whose status is still unread is ignored.
- R7: When status and count are both frozen, the first read returns the status, whichever was latched first. Requesting both in one command equals two separate commands.
- R8: A control write with bits 7:6 equal to the channel number (0 to 2) and bits 5:4 not 00 is a mode word. It discards that channel's pending count and status and puts its byte pointer back on the low byte.
- R9: A control write with bits 7:6 equal to the channel number and bits 5:4 = 00 freezes only that channel's count.
- R10: In access code 11, live reads alternate between the low and high byte. Capturing a count puts the pointer on the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 2 | 0 to 2: channel data ports, 3: control port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle that `rd_en` is high, zero otherwise |
| live_cnt | input | NUM_CH*16 | Live counts, channel 0 in the low bits |
| cnt_mode | input | NUM_CH*3 | Counting mode of each channel |
| acc_mode | input | NUM_CH*2 | Access code: 01 low byte, 10 high byte, 11 low then high |
| bcd_sel | input | NUM_CH | BCD counting flag of each channel |
| out_lvl | input | NUM_CH | Current output level of each channel |
| null_flag | input | NUM_CH | Null-count flag of each channel |

## Verification
The bench builds the block with the default of three channels. This lets it give each channel a different access code (11 on channel 0, 01 on channel 1, 10 on channel 2), so the single-read and two-read release paths run side by side. With three channels, one command can also select a subset such as channels 0 and 2 and leave channel 1 alone. That shows independent release, and it also exercises the channel-select bit positions and the status bytes of distinct configurations.

// File: rtl/pit_rb_pkg.sv
package pit_rb_pkg;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 16;
    localparam int MODE_W = 3;
    localparam int ACC_W  = 2;

    localparam logic [ACC_W-1:0] ACC_LOW  = 2'b01;
    localparam logic [ACC_W-1:0] ACC_HIGH = 2'b10;
    localparam logic [ACC_W-1:0] ACC_WORD = 2'b11;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_CNT,
        CH_STS,
        CH_BOTH
    } ch_state_t;
endpackage

// File: rtl/pit_rb_cmd_dec.sv
module pit_rb_cmd_dec
    import pit_rb_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [NUM_CH-1:0] cnt_req,
    output logic [NUM_CH-1:0] sts_req,
    output logic [NUM_CH-1:0] mode_wr
);
    localparam logic [1:0] CTRL_ADDR = 2'd3;

    logic is_ctrl;
    logic is_snap;

    assign is_ctrl = wr_en && (addr == CTRL_ADDR);
    assign is_snap = is_ctrl && (wdata[7:6] == 2'b11) && !wdata[0];

    always_comb begin
        cnt_req = '0;
        sts_req = '0;
        mode_wr = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (is_snap && wdata[i+1]) begin
                cnt_req[i] = !wdata[5];
                sts_req[i] = !wdata[4];
            end else if (is_ctrl && (wdata[7:6] == 2'(i))) begin
                if (wdata[5:4] == 2'b00) begin
                    cnt_req[i] = 1'b1;
                end else begin
                    mode_wr[i] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pit_rb_chan.sv
module pit_rb_chan
    import pit_rb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_req,
    input  logic              sts_req,
    input  logic              mode_wr,
    input  logic              rd_hit,
    input  logic [CNT_W-1:0]  live,
    input  logic [MODE_W-1:0] cmode,
    input  logic [ACC_W-1:0]  acc,
    input  logic              bcd,
    input  logic              out_level,
    input  logic              nul,
    output logic [DATA_W-1:0] rd_byte,
    output logic              cnt_held,
    output logic              sts_held,
    output logic [CNT_W-1:0]  frozen
);
    ch_state_t         state, state_nxt;
    logic [DATA_W-1:0] sts_q;
    logic              hi_ptr, hi_ptr_nxt;
    logic              cnt_pend, sts_pend;
    logic              serve_sts, serve_cnt, release_cnt;
    logic              keep_cnt, keep_sts, take_cnt, take_sts;
    logic              pick_hi;
    logic [CNT_W-1:0]  src;

    always_comb begin
        unique case (state)
            CH_IDLE: begin cnt_pend = 1'b0; sts_pend = 1'b0; end
            CH_CNT:  begin cnt_pend = 1'b1; sts_pend = 1'b0; end
            CH_STS:  begin cnt_pend = 1'b0; sts_pend = 1'b1; end
            CH_BOTH: begin cnt_pend = 1'b1; sts_pend = 1'b1; end
            default: begin cnt_pend = 1'b0; sts_pend = 1'b0; end
        endcase
    end

    assign pick_hi     = (acc == ACC_HIGH) || ((acc == ACC_WORD) && hi_ptr);
    assign serve_sts   = rd_hit && sts_pend;
    assign serve_cnt   = rd_hit && !sts_pend;
    assign release_cnt = serve_cnt && cnt_pend && ((acc != ACC_WORD) || hi_ptr);
    assign keep_cnt    = cnt_pend && !release_cnt;
    assign keep_sts    = sts_pend && !serve_sts;
    assign take_cnt    = cnt_req && !keep_cnt && !mode_wr;
    assign take_sts    = sts_req && !keep_sts && !mode_wr;

    // next state: read applied first, then latch requests, mode word overrides
    always_comb begin
        state_nxt = state;
        if (mode_wr) begin
            state_nxt = CH_IDLE;
        end else begin
            unique case ({keep_sts || take_sts, keep_cnt || take_cnt})
                2'b00: state_nxt = CH_IDLE;
                2'b01: state_nxt = CH_CNT;
                2'b10: state_nxt = CH_STS;
                2'b11: state_nxt = CH_BOTH;
                default: state_nxt = CH_IDLE;
            endcase
        end
        hi_ptr_nxt = hi_ptr;
        if (mode_wr || take_cnt) begin
            hi_ptr_nxt = 1'b0;
        end else if (serve_cnt && (acc == ACC_WORD)) begin
            hi_ptr_nxt = !hi_ptr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= CH_IDLE;
            hi_ptr <= 1'b0;
            frozen <= '0;
            sts_q  <= '0;
        end else begin
            state  <= state_nxt;
            hi_ptr <= hi_ptr_nxt;
            if (take_cnt) begin
                frozen <= live;
            end
            if (take_sts) begin
                sts_q <= {out_level, nul, acc, cmode, bcd};
            end
        end
    end

    // outputs
    always_comb begin
        src      = cnt_pend ? frozen : live;
        cnt_held = cnt_pend;
        sts_held = sts_pend;
        rd_byte  = '0;
        if (serve_sts) begin
            rd_byte = sts_q;
        end else if (serve_cnt) begin
            rd_byte = pick_hi ? src[CNT_W-1:DATA_W] : src[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/pit_readback.sv
module pit_readback
    import pit_rb_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [1:0]               addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    input  logic [NUM_CH*CNT_W-1:0]  live_cnt,
    input  logic [NUM_CH*MODE_W-1:0] cnt_mode,
    input  logic [NUM_CH*ACC_W-1:0]  acc_mode,
    input  logic [NUM_CH-1:0]        bcd_sel,
    input  logic [NUM_CH-1:0]        out_lvl,
    input  logic [NUM_CH-1:0]        null_flag
);
    logic [NUM_CH-1:0]       cnt_req, sts_req, mode_wr;
    logic [NUM_CH-1:0]       cnt_held, sts_held;
    logic [NUM_CH*CNT_W-1:0] lat_cnt_flat;
    logic [DATA_W-1:0]       ch_byte [NUM_CH];

    pit_rb_cmd_dec #(.NUM_CH(NUM_CH)) u_dec (
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .cnt_req (cnt_req),
        .sts_req (sts_req),
        .mode_wr (mode_wr)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pit_rb_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt_req   (cnt_req[g]),
            .sts_req   (sts_req[g]),
            .mode_wr   (mode_wr[g]),
            .rd_hit    (rd_en && (addr == 2'(g))),
            .live      (live_cnt[g*CNT_W +: CNT_W]),
            .cmode     (cnt_mode[g*MODE_W +: MODE_W]),
            .acc       (acc_mode[g*ACC_W +: ACC_W]),
            .bcd       (bcd_sel[g]),
            .out_level (out_lvl[g]),
            .nul       (null_flag[g]),
            .rd_byte   (ch_byte[g]),
            .cnt_held  (cnt_held[g]),
            .sts_held  (sts_held[g]),
            .frozen    (lat_cnt_flat[g*CNT_W +: CNT_W])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            rdata = rdata | ch_byte[i];
        end
    end
endmodule

// File: rtl/pit_rb_chk.sv
module pit_rb_chk
    import pit_rb_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic                     rd_en,
    input logic [1:0]               addr,
    input logic [DATA_W-1:0]        wdata,
    input logic [NUM_CH*ACC_W-1:0]  acc_mode,
    input logic [NUM_CH-1:0]        cnt_held,
    input logic [NUM_CH-1:0]        sts_held,
    input logic [NUM_CH*CNT_W-1:0]  lat_cnt_flat
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        localparam logic [1:0] CH = 2'(g);

        AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == 2'd3 && wdata[7:6] == CH && wdata[5:4] != 2'b00)
            |=> (!cnt_held[g] && !sts_held[g])); // R8

        AST_BOTH_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == 2'd3 && wdata[7:4] == 4'b1100 && wdata[g+1] && !wdata[0])
            |=> (cnt_held[g] && sts_held[g])); // R7

        AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_held[g] && !rd_en)
            |=> $stable(lat_cnt_flat[g*CNT_W +: CNT_W])); // R5

        AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && addr == CH && sts_held[g] && !wr_en)
            |=> (!sts_held[g] && cnt_held[g] == $past(cnt_held[g]))); // R7

        AST_SINGLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && addr == CH && !sts_held[g] && cnt_held[g] && !wr_en
             && acc_mode[g*ACC_W +: ACC_W] != 2'b11)
            |=> !cnt_held[g]); // R4
    end
endmodule

bind pit_readback pit_rb_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/pit_readback_tb.sv
`timescale 1ns/1ps
module pit_readback_tb;
    localparam int NCH = 3;
    localparam logic [1:0] OP_SET = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;
    localparam int NV = 59;
    // fields: req[23:20] op[19:18] port[17:16] value[15:0]
    localparam logic [23:0] VEC [NV] = '{
        {4'd3, OP_SET, 2'd0, 16'h1234}, {4'd3, OP_SET, 2'd1, 16'hAB56},
        {4'd3, OP_SET, 2'd2, 16'h78CD}, {4'd3, OP_WR,  2'd3, 16'h00DE}, // R3 all counts
        {4'd4, OP_SET, 2'd0, 16'h9999}, {4'd4, OP_SET, 2'd1, 16'h1111},
        {4'd4, OP_SET, 2'd2, 16'h2222},
        {4'd4, OP_RD,  2'd0, 16'h0034}, {4'd4, OP_RD,  2'd0, 16'h0012}, // R4 two reads
        {4'd10,OP_RD,  2'd0, 16'h0099}, {4'd10,OP_RD,  2'd0, 16'h0099}, // R10 live pair
        {4'd4, OP_RD,  2'd1, 16'h0056}, {4'd4, OP_RD,  2'd1, 16'h0011}, // R4 low only
        {4'd4, OP_RD,  2'd2, 16'h0078}, {4'd4, OP_RD,  2'd2, 16'h0022}, // R4 high only
        {4'd5, OP_SET, 2'd0, 16'h5A6B}, {4'd5, OP_WR,  2'd3, 16'h00D2},
        {4'd5, OP_SET, 2'd0, 16'h4321}, {4'd5, OP_WR,  2'd3, 16'h00D2}, // R5 repeat
        {4'd5, OP_RD,  2'd0, 16'h006B}, {4'd5, OP_RD,  2'd0, 16'h005A},
        {4'd5, OP_RD,  2'd0, 16'h0021},
        {4'd7, OP_WR,  2'd3, 16'h00D2}, {4'd7, OP_WR,  2'd3, 16'h00E2}, // R7 count then status
        {4'd7, OP_RD,  2'd0, 16'h00B6}, {4'd7, OP_RD,  2'd0, 16'h0021},
        {4'd7, OP_RD,  2'd0, 16'h0043},
        {4'd7, OP_SET, 2'd1, 16'h00F0}, {4'd7, OP_WR,  2'd3, 16'h00C4}, // R7 both at once
        {4'd6, OP_RD,  2'd1, 16'h0054}, {4'd7, OP_SET, 2'd1, 16'h0077},
        {4'd7, OP_RD,  2'd1, 16'h00F0}, {4'd4, OP_RD,  2'd1, 16'h0077},
        {4'd3, OP_SET, 2'd0, 16'h0102}, {4'd3, OP_SET, 2'd2, 16'h0304},
        {4'd3, OP_WR,  2'd3, 16'h00DA}, {4'd3, OP_SET, 2'd0, 16'hFFFF}, // R3 subset
        {4'd3, OP_SET, 2'd2, 16'hEEEE},
        {4'd3, OP_RD,  2'd0, 16'h0002}, {4'd3, OP_RD,  2'd0, 16'h0001},
        {4'd3, OP_RD,  2'd2, 16'h0003},
        {4'd9, OP_SET, 2'd2, 16'h5566}, {4'd9, OP_WR,  2'd3, 16'h0080}, // R9 single latch
        {4'd9, OP_SET, 2'd2, 16'h0000},
        {4'd9, OP_RD,  2'd2, 16'h0055}, {4'd9, OP_RD,  2'd2, 16'h0000},
        {4'd8, OP_SET, 2'd0, 16'hAABB}, {4'd8, OP_WR,  2'd3, 16'h00D2}, // R8 mode clears
        {4'd8, OP_WR,  2'd3, 16'h0030}, {4'd8, OP_SET, 2'd0, 16'hCCDD},
        {4'd8, OP_RD,  2'd0, 16'h00DD}, {4'd8, OP_RD,  2'd0, 16'h00CC},
        {4'd8, OP_WR,  2'd3, 16'h00E2}, {4'd8, OP_WR,  2'd3, 16'h0030},
        {4'd8, OP_RD,  2'd0, 16'h00DD},
        {4'd2, OP_WR,  2'd3, 16'h00D3}, {4'd2, OP_SET, 2'd0, 16'h0F1E}, // R2 bit0 set
        {4'd2, OP_RD,  2'd0, 16'h000F}, {4'd2, OP_RD,  2'd0, 16'h001E}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [NCH*16-1:0] live_cnt = '0;
    logic [NCH*3-1:0]  cnt_mode = {3'b000, 3'b010, 3'b011};
    logic [NCH*2-1:0]  acc_mode = {2'b10, 2'b01, 2'b11};
    logic [NCH-1:0]    bcd_sel  = 3'b100;
    logic [NCH-1:0]    out_lvl  = 3'b101;
    logic [NCH-1:0]    null_flag = 3'b010;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pit_readback #(.NUM_CH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .live_cnt(live_cnt), .cnt_mode(cnt_mode),
        .acc_mode(acc_mode), .bcd_sel(bcd_sel), .out_lvl(out_lvl), .null_flag(null_flag)
    );

    task automatic set_live(input int ch, input logic [15:0] v);
        @(negedge clk);
        live_cnt[ch*16 +: 16] = v;
    endtask

    task automatic bus_wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 2'd3; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1;
        total++;
        if (rdata !== exp) begin
            bad++;
            $display("FAIL %s port %0d: got %02h expected %02h", req, a, rdata, exp);
        end
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state: live low byte first, then high
        set_live(0, 16'hBEEF);
        bus_rd(2'd0, 8'hEF, "R1");
        bus_rd(2'd0, 8'hBE, "R1");
        bus_rd(2'd1, 8'h00, "R1");

        for (int k = 0; k < NV; k++) begin
            logic [3:0]  rq;
            logic [1:0]  op, pt;
            logic [15:0] v;
            {rq, op, pt, v} = VEC[k];
            unique case (op)
                OP_SET: set_live(int'(pt), v);
                OP_WR:  bus_wr(v[7:0]);
                default: bus_rd(pt, v[7:0], $sformatf("R%0d", rq));
            endcase
        end

        // R6 repeated status latch ignored, status sampled at latch time
        bus_wr(8'hE8);
        @(negedge clk) out_lvl[2] = 1'b0;
        bus_wr(8'hE8);
        bus_rd(2'd2, 8'hA1, "R6");
        bus_rd(2'd2, 8'h00, "R6");
        bus_wr(8'hE8);
        bus_rd(2'd2, 8'h21, "R6");

        // R8 mode word between the two bytes of a frozen count
        set_live(0, 16'h1357);
        bus_wr(8'hD2);
        bus_rd(2'd0, 8'h57, "R8");
        bus_wr(8'h30);
        set_live(0, 16'h2468);
        bus_rd(2'd0, 8'h68, "R8");
        bus_rd(2'd0, 8'h24, "R8");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule